// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a stereo serial audio stream (a bit clock, a frame clock that marks the left and right halves, and one data line) and turns it into pairs of 16-bit two's-complement samples. Words arrive MSB first. A single select input chooses the framing at run time. Low selects right-justified framing, where each word ends on the last bit clock before the frame clock edge. High selects I2S framing, where the MSB follows the frame clock edge after a one-bit delay.

All four serial inputs are brought into the system clock domain through a synchroniser. A rising edge of the bit clock is detected there and drives one shared shift engine. The framing logic decides, for the active format, which bits form a word and which channel that word belongs to. Once the right word of a frame is complete, the left and right samples are presented together and a one-cycle valid strobe is raised.

A change of format is applied only at a frame start as seen by the current format. The frame that straddles the change is dropped, so no sample built from mixed framing ever leaves the block.

Top module: `dual_fmt_audio_rx`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and left_o and right_o are all zeros.
- R2: With fmt_i2s_i = 0 (right-justified), the half where the frame clock is high is the left channel. The 16 bits sampled on the last 16 bit-clock rising edges before a frame clock change form the word of the half that ends, MSB first. Words pass through unmodified, including 16'h8000 and 16'h7FFF.
- R3: In right-justified mode, a half longer than 16 bit clocks has its extra leading bits ignored, whatever their values.
- R4: With fmt_i2s_i = 1 (I2S), the half where the frame clock is low is the left channel. The bit on the first rising edge after a frame clock change is skipped, and the next 16 bits form the word, MSB first. This holds even when a half is exactly 16 bit clocks long and the LSB lands in the following half.
- R5: In I2S mode, bits after the 16th data bit of a half are ignored, whatever their values.
- R6: valid_o is high for exactly one system clock cycle after each right word completes. left_o and right_o change only in that cycle and then hold.
- R7: A format change takes effect only at a frame start of the current format. The frame in progress when the change is applied, and the first new-format frame, produce no output. Output resumes with the next complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock; data sampled on its rising edge |
| lrclk_i | input | 1 | Frame clock selecting the channel half |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i2s_i | input | 1 | Framing select: 0 right-justified, 1 I2S |
| left_o | output | 16 | Left sample of the last delivered frame |
| right_o | output | 16 | Right sample of the last delivered frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions assume that the bit clock runs well below the system clock, so that every bit-clock rising edge is at least several system cycles from the next one. Under that assumption two word completions can never fall in adjacent cycles. They also assume that the data line and the frame clock are stable around each bit-clock rising edge. The stimulus holds each bit-clock level for four system clocks and changes data and frame clock only when the bit clock falls. The format select is changed only at the start of a frame, and a switch out of I2S is made with halves longer than 16 bits, so that the last I2S right word finishes before the new framing begins.

// File: rtl/dfar_pkg.sv
package dfar_pkg;
  localparam int unsigned SAMPLE_W = 16;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef enum logic {FMT_RJ = 1'b0, FMT_I2S = 1'b1} fmt_e;
endpackage

// File: rtl/dfar_sync.sv
module dfar_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dfar_shift.sv
module dfar_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_en_i,
  input  logic         sd_i,
  input  logic         lr_i,
  output logic         change_o,
  output logic         lr_prev_o,
  output logic         slot_end_o,
  output logic [W-1:0] rj_word_o,
  output logic [W-1:0] i2s_word_o
);
  localparam int unsigned CNT_W = $clog2(W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(W - 1);

  logic [W-1:0]     sr_q;
  logic             lr_q;
  logic [CNT_W-1:0] cnt_q;

  assign change_o   = bit_en_i && (lr_i != lr_q);
  // 16th rise after the frame edge: the I2S word's LSB (may be the next edge)
  assign slot_end_o = bit_en_i && (cnt_q == CNT_END);
  assign rj_word_o  = sr_q;
  assign i2s_word_o = {sr_q[W-2:0], sd_i};
  assign lr_prev_o  = lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      lr_q  <= 1'b0;
      cnt_q <= CNT_MAX;
    end else if (bit_en_i) begin
      sr_q <= {sr_q[W-2:0], sd_i};
      lr_q <= lr_i;
      if (change_o)              cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dfar_framer.sv
module dfar_framer
  import dfar_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fmt_i,
  input  logic         change_i,
  input  logic         lr_now_i,
  input  logic         lr_prev_i,
  input  logic         slot_end_i,
  input  logic [W-1:0] rj_word_i,
  input  logic [W-1:0] i2s_word_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o,
  output logic         mode_o
);
  fmt_e         mode_q;
  logic         have_left_q, drop_q, valid_q;
  logic [W-1:0] left_hold_q, left_q, right_q;

  logic         left_lvl, boundary, do_switch, cap, is_left;
  logic [W-1:0] word;

  always_comb begin
    left_lvl  = (mode_q == FMT_I2S) ? 1'b0 : 1'b1;
    boundary  = change_i && (lr_now_i == left_lvl);
    do_switch = boundary && (fmt_e'(fmt_i) != mode_q);
    cap       = !do_switch && ((mode_q == FMT_I2S) ? slot_end_i : change_i);
    word      = (mode_q == FMT_I2S) ? i2s_word_i : rj_word_i;
    is_left   = (lr_prev_i == left_lvl);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= FMT_RJ;
      have_left_q <= 1'b0;
      drop_q      <= 1'b0;
      valid_q     <= 1'b0;
      left_hold_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (do_switch) begin
        mode_q      <= fmt_e'(fmt_i);
        have_left_q <= 1'b0;
        drop_q      <= 1'b1;
      end else if (cap) begin
        if (is_left) begin
          left_hold_q <= word;
          have_left_q <= 1'b1;
        end else begin
          have_left_q <= 1'b0;
          drop_q      <= 1'b0;
          if (have_left_q && !drop_q) begin
            left_q  <= left_hold_q;
            right_q <= word;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/dual_fmt_audio_rx.sv
module dual_fmt_audio_rx
  import dfar_pkg::*;
#(
  parameter int unsigned W           = SAMPLE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_i,
  input  logic         lrclk_i,
  input  logic         sdata_i,
  input  logic         fmt_i2s_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  logic [3:0]   sync_w;
  logic         bclk_d_q, bit_en;
  logic         change_w, lr_prev_w, slot_end_w, mode_w;
  logic [W-1:0] rj_word_w, i2s_word_w;

  dfar_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fmt_i2s_i, bclk_i, lrclk_i, sdata_i}),
    .q_o   (sync_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_d_q <= 1'b0;
    else         bclk_d_q <= sync_w[2];
  end

  assign bit_en = sync_w[2] && !bclk_d_q;

  dfar_shift #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en),
    .sd_i      (sync_w[0]),
    .lr_i      (sync_w[1]),
    .change_o  (change_w),
    .lr_prev_o (lr_prev_w),
    .slot_end_o(slot_end_w),
    .rj_word_o (rj_word_w),
    .i2s_word_o(i2s_word_w)
  );

  dfar_framer #(.W(W)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fmt_i     (sync_w[3]),
    .change_i  (change_w),
    .lr_now_i  (sync_w[1]),
    .lr_prev_i (lr_prev_w),
    .slot_end_i(slot_end_w),
    .rj_word_i (rj_word_w),
    .i2s_word_i(i2s_word_w),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .mode_o    (mode_w)
  );
endmodule

// File: rtl/dfar_chk.sv
module dfar_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         mode_i
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && left_o == '0 && right_o == '0));

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  output_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R7
  switch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i)) |-> !valid_o);
endmodule

bind dual_fmt_audio_rx dfar_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_o(valid_o),
  .left_o (left_o),
  .right_o(right_o),
  .mode_i (mode_w)
);

// File: tb/dual_fmt_audio_rx_test.sv
module dual_fmt_audio_rx_test;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0, fmt = 1'b0;
  logic [15:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_valid = 1'b0;
  logic        prev_lsb = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  dual_fmt_audio_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .lrclk_i(lrclk),
    .sdata_i(sdata), .fmt_i2s_i(fmt),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic lvl, input logic b);
    @(negedge clk);
    lrclk = lvl;
    sdata = b;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_frame(input logic i2s, input int slot, input logic [15:0] l,
                            input logic [15:0] r, input logic expect_out, input string tag);
    if (expect_out) begin
      exp_q.push_back({l, r});
      tag_q.push_back(tag);
    end
    fmt = i2s;
    for (int h = 0; h < 2; h++) begin
      logic        lvl;
      logic [15:0] w;
      lvl = (h == 0) ? ~i2s : i2s;
      w   = (h == 0) ? l : r;
      for (int i = 0; i < slot; i++) begin
        logic b;
        if (!i2s) begin
          if (i < slot - 16) b = 1'($urandom);
          else               b = w[15 - (i - (slot - 16))];
        end else begin
          if (i == 0)      b = prev_lsb;
          else if (i < 17) b = w[16 - i];
          else             b = 1'($urandom);
        end
        drive_bit(lvl, b);
      end
      prev_lsb = w[0];
    end
  endtask

  // monitor: pop and compare on each strobe, and check the strobe width
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (prev_valid) check("R6 pulse width", {31'd0, valid_o}, 32'd0);
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected output", {left_o, right_o}, 32'hxxxx_xxxx);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " left"}, {16'd0, left_o}, {16'd0, e[31:16]});
          check({t, " right"}, {16'd0, right_o}, {16'd0, e[15:0]});
        end
      end
      prev_valid = valid_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, valid_o}, 32'd0);
    check("R1 left", {16'd0, left_o}, 32'd0);
    check("R1 right", {16'd0, right_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R2 right-justified, 16-bit halves
    send_frame(1'b0, 16, 16'h1234, 16'hABCD, 1'b1, "R2");
    send_frame(1'b0, 16, 16'h8000, 16'h7FFF, 1'b1, "R2");
    send_frame(1'b0, 16, 16'hFFFF, 16'h0001, 1'b1, "R2");
    // R3 leading padding ignored
    send_frame(1'b0, 24, 16'h5A5A, 16'hC3C3, 1'b1, "R3");
    send_frame(1'b0, 24, 16'h0F0F, 16'hF0F0, 1'b0, "R7");
    // R7 switch to I2S: straddling and first new frame dropped; R5 trailing pad
    send_frame(1'b1, 20, 16'h1111, 16'h2222, 1'b0, "R7");
    send_frame(1'b1, 20, 16'h3C5A, 16'hA5C3, 1'b1, "R5");
    send_frame(1'b1, 20, 16'h8001, 16'h7FFE, 1'b1, "R5");
    // R4 I2S with 16-bit halves (LSB in next half)
    send_frame(1'b1, 16, 16'hDEAD, 16'hBEEF, 1'b1, "R4");
    send_frame(1'b1, 16, 16'h0000, 16'hFFFF, 1'b1, "R4");
    send_frame(1'b1, 16, 16'h4321, 16'h8765, 1'b1, "R4");
    send_frame(1'b1, 20, 16'h6E6E, 16'h9191, 1'b1, "R5");
    // R7 switch back to right-justified
    send_frame(1'b0, 16, 16'h3333, 16'h4444, 1'b0, "R7");
    send_frame(1'b0, 16, 16'h2468, 16'h1357, 1'b1, "R7");
    send_frame(1'b0, 16, 16'h8000, 16'h7FFF, 1'b1, "R2");
    // closing edge for the last right-justified word
    for (int i = 0; i < 4; i++) drive_bit(1'b1, 1'b0);
    repeat (20) @(negedge clk);

    // R6 outputs hold after the last strobe
    check("R6 hold left", {16'd0, left_o}, 32'h0000_8000);
    check("R6 hold right", {16'd0, right_o}, 32'h0000_7FFF);
    // R7 every expected pair delivered, nothing extra
    check("R7 pending", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule